// File: doc/BRIEF.md
# Disjunctive Temporal Constraint Checker

This block judges whether a candidate schedule satisfies a set of disjunctive timing rules. The schedule is held in a small register file of unsigned event times, one per event, written through a simple write port. Event 0 is the origin of time and always reads as zero. A run begins with a start pulse. Constraint entries then arrive one per cycle on a valid/ready handshake. Each entry names two events, `lam` and `gam`, and a signed offset `z`, and asks whether `time[lam] - time[gam] <= z`.

Entries are grouped into clauses. A flag on an entry marks the end of its clause, and a second flag marks the end of the whole run. A clause is satisfied when at least one of its bounds holds. The run passes only if every clause is satisfied. Each bound is decided by a sign test on two ripple-carry chains. The first chain forms the difference of the two times. The second adds the offset to that difference. The two carries are combined with AND when the offset is zero or negative, and with OR when it is positive.

When the final entry has been taken, the block pulses `done` for one cycle and reports a pass flag. On a failed run it also reports the position of the first clause that was not satisfied.

Top module: `dtc_checker`

## Requirements
- R1: Event 0 always reads as time zero. A write to address 0 is ignored and has no effect on later bound results.
- R2: A non-null entry holds exactly when `time[ent_lambda] - time[ent_gamma] <= z`. Here `ent_z` is a TW+1-bit two's-complement value and the times are unsigned TW-bit values. The boundary values are covered, including z = -(2^TW) (never holds) and z = 2^TW-1 (always holds).
- R3: A clause is satisfied when any of its non-null entries holds. An entry with `ent_null`=1 contributes nothing. A clause made only of null entries is unsatisfied.
- R4: `pass` rises together with `done` when every clause of the run was satisfied. It holds until the next `start`, which clears it. `pass` and `fail_valid` are never both 1.
- R5: `fail_clause` is the zero-based position of the first unsatisfied clause since `start`, and `fail_valid` is then 1. A later unsatisfied clause does not change either output.
- R6: An accepted entry ends its clause when `ent_last` or `ent_final` is 1. `ent_final` also ends the run. `done` is 1 for exactly the one cycle after the final entry is accepted.
- R7: `ent_ready` is 1 only while a run is active and `start` is 0. An entry offered while `ent_ready` is 0 is ignored.
- R8: A `start` pulse during a run restarts it. The clause position returns to 0, and the pending clause and any latched failure are discarded.
- R9: After reset, `done`, `pass`, `fail_valid` and `ent_ready` are 0 and every event time is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sched_we | input | 1 | Schedule write enable |
| sched_addr | input | EW | Event number to write |
| sched_data | input | TW | Event time to write |
| start | input | 1 | Begin (or restart) a run |
| ent_valid | input | 1 | Constraint entry offered |
| ent_ready | output | 1 | Entry accepted this cycle when valid |
| ent_lambda | input | EW | Minuend event of the bound |
| ent_gamma | input | EW | Subtrahend event of the bound |
| ent_z | input | TW+1 | Signed offset (two's complement) |
| ent_null | input | 1 | Entry carries no bound |
| ent_last | input | 1 | Entry closes its clause |
| ent_final | input | 1 | Entry closes its clause and the run |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run satisfied all clauses |
| fail_valid | output | 1 | A failing clause has been recorded |
| fail_clause | output | CW | Position of the first failing clause |

## Verification
Two events can coincide on the final entry: closing the last clause, which may record a failure, and finishing the run, which decides `pass`. The bench provokes this with runs whose final clause is the first one to fail and runs whose final clause holds after an earlier failure. It checks in the `done` cycle that `fail_clause` and `pass` agree with a behavioural model that uses integer arithmetic. A second collision is a restart pulse arriving in the middle of a run. The bench checks that the restarted run's result carries nothing from the abandoned one.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_BUSY = 1'b1
  } run_e;
endpackage

// File: rtl/dtc_sched_rf.sv
module dtc_sched_rf #(
  parameter int NEV = 8,
  parameter int TW  = 8,
  parameter int EW  = (NEV > 1) ? $clog2(NEV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [EW-1:0] waddr,
  input  logic [TW-1:0] wdata,
  input  logic [EW-1:0] raddr_a,
  output logic [TW-1:0] rdata_a,
  input  logic [EW-1:0] raddr_b,
  output logic [TW-1:0] rdata_b
);
  localparam int DEPTH = 1 << EW;

  logic [TW-1:0] slot [DEPTH];

  // Slot 0 is the origin; slots past NEV do not exist and read as zero.
  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    if (e == 0 || e >= NEV) begin : g_zero
      assign slot[e] = '0;
    end else begin : g_reg
      logic [TW-1:0] t_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            t_q <= '0;
        else if (we && waddr == EW'(e))        t_q <= wdata;
      end
      assign slot[e] = t_q;
    end
  end

  assign rdata_a = slot[raddr_a];
  assign rdata_b = slot[raddr_b];
endmodule

// File: rtl/dtc_bound_eval.sv
module dtc_bound_eval #(
  parameter int TW = 8
) (
  input  logic [TW-1:0] t_lam,
  input  logic [TW-1:0] t_gam,
  input  logic [TW:0]   z,
  output logic          ok,
  output logic          diff_carry,
  output logic          off_carry
);
  // Carry out of a ripple chain adding a, b and cin.
  function automatic logic chain_carry(input logic [TW-1:0] a,
                                       input logic [TW-1:0] b,
                                       input logic cin);
    logic c;
    c = cin;
    for (int i = 0; i < TW; i++) begin
      c = (a[i] & b[i]) | ((a[i] | b[i]) & c);
    end
    return c;
  endfunction

  logic [TW-1:0] diff;
  logic [TW:0]   mag;
  logic          non_pos;

  // Condition tested: t_gam - t_lam + z >= 0.
  assign diff       = t_gam - t_lam;
  assign diff_carry = chain_carry(t_gam, ~t_lam, 1'b1);
  assign non_pos    = z[TW] | (z == '0);
  assign mag        = -z;

  always_comb begin
    if (non_pos) begin
      off_carry = mag[TW] ? 1'b0 : chain_carry(diff, ~mag[TW-1:0], 1'b1);
      ok        = diff_carry & off_carry;
    end else begin
      off_carry = chain_carry(diff, z[TW-1:0], 1'b0);
      ok        = diff_carry | off_carry;
    end
  end
endmodule

// File: rtl/dtc_clause_seq.sv
module dtc_clause_seq #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          fire,
  input  logic          hit,
  input  logic          ent_last,
  input  logic          ent_final,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail_valid,
  output logic [CW-1:0] fail_clause
);
  import dtc_pkg::*;

  run_e          state_q;
  logic [CW-1:0] idx_q;
  logic          acc_q;
  logic          acc_nx;
  logic          clause_end;
  logic          clause_miss;
  logic          run_end;

  assign acc_nx      = acc_q | hit;
  assign clause_end  = fire & (ent_last | ent_final);
  assign clause_miss = clause_end & ~acc_nx;
  assign run_end     = fire & ent_final;
  assign busy        = (state_q == RUN_BUSY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= RUN_IDLE;
      idx_q       <= '0;
      acc_q       <= 1'b0;
      done        <= 1'b0;
      pass        <= 1'b0;
      fail_valid  <= 1'b0;
      fail_clause <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        state_q     <= RUN_BUSY;
        idx_q       <= '0;
        acc_q       <= 1'b0;
        pass        <= 1'b0;
        fail_valid  <= 1'b0;
        fail_clause <= '0;
      end else if (fire) begin
        if (clause_end) begin
          acc_q <= 1'b0;
          idx_q <= idx_q + 1'b1;
          if (clause_miss && !fail_valid) begin
            fail_valid  <= 1'b1;
            fail_clause <= idx_q;
          end
          if (run_end) begin
            state_q <= RUN_IDLE;
            done    <= 1'b1;
            pass    <= ~fail_valid & acc_nx;
          end
        end else begin
          acc_q <= acc_nx;
        end
      end
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  final_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_end |=> done);
  // R5
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_valid && !start) |=> (fail_valid && $stable(fail_clause)));
  // R4
  pass_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> !fail_valid);
  // R8
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!fail_valid && !pass && !done && busy));
endmodule

// File: rtl/dtc_checker.sv
module dtc_checker #(
  parameter int NEV = 8,
  parameter int TW  = 8,
  parameter int CW  = 4,
  parameter int EW  = (NEV > 1) ? $clog2(NEV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sched_we,
  input  logic [EW-1:0] sched_addr,
  input  logic [TW-1:0] sched_data,
  input  logic          start,
  input  logic          ent_valid,
  output logic          ent_ready,
  input  logic [EW-1:0] ent_lambda,
  input  logic [EW-1:0] ent_gamma,
  input  logic [TW:0]   ent_z,
  input  logic          ent_null,
  input  logic          ent_last,
  input  logic          ent_final,
  output logic          done,
  output logic          pass,
  output logic          fail_valid,
  output logic [CW-1:0] fail_clause
);
  logic [TW-1:0] lam_t;
  logic [TW-1:0] gam_t;
  logic          bnd_ok;
  logic          bnd_dcarry;
  logic          bnd_zcarry;
  logic          busy;
  logic          fire;
  logic          hit;

  dtc_sched_rf #(.NEV(NEV), .TW(TW), .EW(EW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (sched_we),
    .waddr   (sched_addr),
    .wdata   (sched_data),
    .raddr_a (ent_lambda),
    .rdata_a (lam_t),
    .raddr_b (ent_gamma),
    .rdata_b (gam_t)
  );

  dtc_bound_eval #(.TW(TW)) u_eval (
    .t_lam      (lam_t),
    .t_gam      (gam_t),
    .z          (ent_z),
    .ok         (bnd_ok),
    .diff_carry (bnd_dcarry),
    .off_carry  (bnd_zcarry)
  );

  assign ent_ready = busy & ~start;
  assign fire      = ent_valid & ent_ready;
  assign hit       = ~ent_null & bnd_ok;

  dtc_clause_seq #(.CW(CW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .fire        (fire),
    .hit         (hit),
    .ent_last    (ent_last),
    .ent_final   (ent_final),
    .busy        (busy),
    .done        (done),
    .pass        (pass),
    .fail_valid  (fail_valid),
    .fail_clause (fail_clause)
  );

  // R2: equal times give a zero difference, which holds exactly for z >= 0
  eq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && lam_t == gam_t) |-> (bnd_ok == !ent_z[TW]));
  // R2: a time that is not below the other never yields a positive-offset failure
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ent_z[TW] && bnd_dcarry) |-> bnd_ok);
  // R7
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ent_ready);
endmodule

// File: tb/tb_dtc_checker.sv
module tb_dtc_checker;
  localparam int NEV = 8;
  localparam int TW  = 8;
  localparam int CW  = 4;
  localparam int EW  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sched_we = 1'b0;
  logic [EW-1:0] sched_addr = '0;
  logic [TW-1:0] sched_data = '0;
  logic          start = 1'b0;
  logic          ent_valid = 1'b0;
  logic          ent_ready;
  logic [EW-1:0] ent_lambda = '0;
  logic [EW-1:0] ent_gamma = '0;
  logic [TW:0]   ent_z = '0;
  logic          ent_null = 1'b0;
  logic          ent_last = 1'b0;
  logic          ent_final = 1'b0;
  logic          done;
  logic          pass;
  logic          fail_valid;
  logic [CW-1:0] fail_clause;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dtc_checker #(.NEV(NEV), .TW(TW), .CW(CW), .EW(EW)) dut (
    .clk(clk), .rst_n(rst_n), .sched_we(sched_we), .sched_addr(sched_addr),
    .sched_data(sched_data), .start(start), .ent_valid(ent_valid),
    .ent_ready(ent_ready), .ent_lambda(ent_lambda), .ent_gamma(ent_gamma),
    .ent_z(ent_z), .ent_null(ent_null), .ent_last(ent_last),
    .ent_final(ent_final), .done(done), .pass(pass),
    .fail_valid(fail_valid), .fail_clause(fail_clause)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_time [NEV];
  bit m_busy, m_done, m_pass, m_fv, m_acc;
  int m_idx, m_fc;

  always @(posedge clk) begin
    bit rdy, h;
    if (!rst_n) begin
      foreach (m_time[i]) m_time[i] = 0;
      m_busy = 0; m_done = 0; m_pass = 0; m_fv = 0; m_acc = 0;
      m_idx = 0; m_fc = 0;
    end else begin
      rdy = m_busy && !start;
      m_done = 0;
      if (start) begin
        m_busy = 1; m_idx = 0; m_acc = 0; m_fv = 0; m_fc = 0; m_pass = 0;
      end else if (ent_valid && rdy) begin
        h = !ent_null &&
            ((m_time[ent_lambda] - m_time[ent_gamma]) <= int'($signed(ent_z)));
        m_acc = m_acc | h;
        if (ent_last || ent_final) begin
          if (!m_acc && !m_fv) begin m_fv = 1; m_fc = m_idx % (1 << CW); end
          m_idx++;
          if (ent_final) begin m_busy = 0; m_done = 1; m_pass = !m_fv; end
          m_acc = 0;
        end
      end
      if (sched_we && sched_addr != 0) m_time[sched_addr] = sched_data;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk("R6 done", done, m_done);
      chk("R4 pass", pass, m_pass);
      chk("R5 fail_valid", fail_valid, m_fv);
      chk("R5 fail_clause", fail_clause, m_fc);
      chk("R7 ent_ready", ent_ready, m_busy && !start);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    sched_we = 1; sched_addr = EW'(a); sched_data = TW'(d);
    @(negedge clk);
    sched_we = 0;
  endtask

  task automatic kick();
    @(negedge clk);
    ent_valid = 0; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic send(input int lam, input int gam, input int z,
                      input bit nul, input bit lst, input bit fin);
    @(negedge clk);
    ent_valid = 1; ent_lambda = EW'(lam); ent_gamma = EW'(gam);
    ent_z = (TW+1)'(z); ent_null = nul; ent_last = lst; ent_final = fin;
  endtask

  task automatic finish_run(input string tag, input int exp_pass,
                            input int exp_fv, input int exp_fc);
    @(negedge clk);
    ent_valid = 0; ent_last = 0; ent_final = 0; ent_null = 0;
    chk({tag, " done"}, done, 1);
    chk({tag, " pass"}, pass, exp_pass);
    chk({tag, " fail_valid"}, fail_valid, exp_fv);
    if (exp_fv != 0) chk({tag, " fail_clause"}, fail_clause, exp_fc);
    @(negedge clk);
    chk({tag, " done single cycle"}, done, 0);
    chk({tag, " pass held"}, pass, exp_pass);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R9: reset state
    chk("R9 done", done, 0);
    chk("R9 pass", pass, 0);
    chk("R9 fail_valid", fail_valid, 0);
    chk("R9 ent_ready", ent_ready, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R9 ready idle after reset", ent_ready, 0);

    // R7: entries offered while idle are ignored
    @(negedge clk);
    ent_valid = 1; ent_lambda = 3; ent_gamma = 0; ent_z = '0; ent_final = 1;
    repeat (3) begin
      @(negedge clk);
      chk("R7 idle ready low", ent_ready, 0);
      chk("R7 idle no done", done, 0);
    end
    ent_valid = 0; ent_final = 0;

    // R9: untouched times read as zero (1 - 2 = 0 <= 0 holds)
    kick();
    send(1, 2, 0, 0, 0, 1);
    finish_run("R9 zero times", 1, 0, 0);

    wr(1, 10); wr(2, 30); wr(3, 255); wr(4, 100);

    // R2 / R3: several clauses, all satisfied at exact boundaries
    kick();
    send(2, 1, 20, 0, 1, 0);
    send(1, 2, -20, 0, 1, 0);
    send(1, 2, -21, 0, 0, 0);
    send(3, 0, 255, 0, 0, 1);
    finish_run("R2 R3 boundary pass", 1, 0, 0);

    // R1: write to origin ignored
    wr(0, 77);
    kick();
    send(0, 1, -10, 0, 1, 0);
    send(1, 0, 9, 0, 0, 1);
    finish_run("R1 origin zero", 0, 1, 1);

    // R5 / R2: first failure latched, extreme offsets
    kick();
    send(3, 0, 254, 0, 1, 0);
    send(1, 1, -256, 0, 1, 0);
    send(0, 3, -255, 0, 0, 1);
    finish_run("R5 first failure kept", 0, 1, 0);

    // R3: clause holding only a null entry is unsatisfied
    kick();
    send(0, 0, 0, 1, 1, 0);
    send(4, 1, 90, 0, 0, 1);
    finish_run("R3 empty clause", 0, 1, 0);

    // R8: restart mid-run discards failure and clause position
    kick();
    send(3, 0, 0, 0, 1, 0);
    send(1, 2, -21, 0, 0, 0);
    kick();
    send(2, 1, 19, 0, 0, 0);
    send(4, 0, 100, 0, 0, 1);
    finish_run("R8 restart", 1, 0, 0);

    // R6 / R5: final clause is the first to fail, all bounds miss
    kick();
    send(2, 4, -70, 0, 1, 0);
    send(1, 2, -21, 0, 0, 0);
    send(2, 1, 19, 0, 0, 1);
    finish_run("R6 final clause fails", 0, 1, 1);

    // R4: pass cleared by start
    kick();
    chk("R4 pass cleared by start", pass, 0);
    send(4, 3, 0, 0, 0, 1);
    finish_run("R4 rerun pass", 1, 0, 0);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule